// File: doc/BRIEF.md
# Per-Core Reset Control Register

This block is one 32-bit, word-access control register that holds a cluster of four processor cores in or out of reset, plus a set of further reset bits that are kept as plain control levels. The complete register value is driven out continuously as reset levels and can be read back over the register bus.

On every write, the block compares the incoming core bits with the bits already stored. It acts only on the cores whose bit changes:
- A bit that rises from 0 to 1 produces a one-cycle power-off pulse for that core.
- A bit that falls from 1 to 0 produces a one-cycle power-on-and-reset pulse for that core.

Writing the value that is already stored produces no pulses. Several cores can receive pulses in the same cycle. A reset of the block itself produces no pulses; the outputs simply show the reset value.

The bus side has no handshake. A write is taken on any clock edge where `wr_en` is high. The read port returns the register while `rd_en` is high and returns zero otherwise. Because there is no data stream, there is no valid/ready back-pressure to respect.

Top module: `core_rst_ctrl`

## Requirements
- R1: After reset, the register and `rst_level` read 0x3D0F, so all four cores are held in reset. Both pulse outputs stay at zero.
- R2: A write with `wr_en` high is stored at that clock edge. From the next cycle, `rst_level` and `rdata` (with `rd_en` high) return the written value with its reserved bits cleared.
- R3: The bits in mask 0xC2F0 (bits 4 to 7, 9, 14 and 15) are reserved. They ignore writes and always read as zero.
- R4: When a write changes core bit i (bits 3 down to 0, core i at bit i) from 0 to 1, `core_off` bit i is high in the cycle that follows the write edge.
- R5: When a write changes core bit i from 1 to 0, `core_on` bit i is high in the cycle that follows the write edge.
- R6: A core whose bit is unchanged by a write gets no pulse. Rewriting the stored value produces no pulses at all.
- R7: Each pulse lasts exactly one cycle. Pulses for several cores, and of both kinds for different cores, may appear in the same cycle.
- R8: No pulse appears without a write. A core never gets a power-off and a power-on pulse at the same time.
- R9: `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; `wdata` is stored at this edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read select |
| rdata | output | 32 | Read data; zero when `rd_en` is low |
| rst_level | output | 32 | Stored register value, driven out as reset levels |
| core_off | output | 4 | Per-core power-off pulses |
| core_on | output | 4 | Per-core power-on-and-reset pulses |

## Verification
A corrupted stored value appears on `rst_level` in the cycle after the write. It also skews the comparison at the next write, which then produces a pulse of the wrong direction or a missing pulse for the affected core. A reserved bit that is wrongly stored is visible at once on `rst_level`. A pulse stage that holds its value shows up as a pulse lasting a second cycle. The scenarios therefore check the pulses in the cycle after each write and again one cycle later, and cover rewrites of the same value, swaps of mixed directions and back-to-back writes.

// File: rtl/crst_pkg.sv
package crst_pkg;
  localparam int CRST_WORD_W = 32;

  typedef struct packed {
    logic off;
    logic on;
  } core_cmd_t;

  function automatic logic [CRST_WORD_W-1:0] crst_keep(
    input logic [CRST_WORD_W-1:0] val,
    input logic [CRST_WORD_W-1:0] rsvd
  );
    return val & ~rsvd;
  endfunction
endpackage

// File: rtl/crst_reg_store.sv
module crst_reg_store #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_3D0F,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h0000_C2F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] WR_MASK = ~RSVD_MASK;
  localparam logic [DATA_W-1:0] RST_Q = RESET_VAL & WR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_Q;
    end else if (wr_en) begin
      q <= wdata & WR_MASK;
    end
  end
endmodule

// File: rtl/crst_core_cmd.sv
module crst_core_cmd
  import crst_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NUM_CORES-1:0] old_bits,
  input  logic [NUM_CORES-1:0] new_bits,
  output logic [NUM_CORES-1:0] off_o,
  output logic [NUM_CORES-1:0] on_o
);
  core_cmd_t cmd [NUM_CORES];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic changed;
    assign changed = wr_en & (old_bits[i] ^ new_bits[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd[i] <= '0;
      end else begin
        cmd[i].off <= changed & new_bits[i];
        cmd[i].on  <= changed & ~new_bits[i];
      end
    end

    assign off_o[i] = cmd[i].off;
    assign on_o[i]  = cmd[i].on;
  end
endmodule

// File: rtl/core_rst_ctrl.sv
module core_rst_ctrl
  import crst_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = CRST_WORD_W,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_3D0F,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h0000_C2F0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 rd_en,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    rst_level,
  output logic [NUM_CORES-1:0] core_off,
  output logic [NUM_CORES-1:0] core_on
);
  logic [DATA_W-1:0] cur_q;

  crst_reg_store #(
    .DATA_W(DATA_W),
    .RESET_VAL(RESET_VAL),
    .RSVD_MASK(RSVD_MASK)
  ) u_store (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .wdata(wdata),
    .q(cur_q)
  );

  crst_core_cmd #(
    .NUM_CORES(NUM_CORES)
  ) u_cmd (
    .clk(clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .old_bits(cur_q[NUM_CORES-1:0]),
    .new_bits(wdata[NUM_CORES-1:0]),
    .off_o(core_off),
    .on_o(core_on)
  );

  assign rst_level = cur_q;
  assign rdata = rd_en ? cur_q : '0;
endmodule

// File: rtl/core_rst_ctrl_chk.sv
module core_rst_ctrl_chk #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RSVD_MASK = 32'h0000_C2F0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [DATA_W-1:0]    wdata,
  input logic                 rd_en,
  input logic [DATA_W-1:0]    rdata,
  input logic [DATA_W-1:0]    rst_level,
  input logic [NUM_CORES-1:0] core_off,
  input logic [NUM_CORES-1:0] core_on
);
  // R2
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rst_level == ($past(wdata) & ~RSVD_MASK));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_level & RSVD_MASK) == '0);

  // R4
  off_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> core_off == ($past(wdata[NUM_CORES-1:0]) & ~$past(rst_level[NUM_CORES-1:0])));

  // R5
  on_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> core_on == (~$past(wdata[NUM_CORES-1:0]) & $past(rst_level[NUM_CORES-1:0])));

  // R8
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (core_off == '0 && core_on == '0));

  // R8
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_off & core_on) == '0);

  // R9
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

bind core_rst_ctrl core_rst_ctrl_chk #(
  .NUM_CORES(NUM_CORES),
  .DATA_W(DATA_W),
  .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .wr_en(wr_en),
  .wdata(wdata),
  .rd_en(rd_en),
  .rdata(rdata),
  .rst_level(rst_level),
  .core_off(core_off),
  .core_on(core_on)
);

// File: tb/core_rst_ctrl_tb.sv
module core_rst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RSVD = 32'h0000_C2F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [31:0] rst_level;
  logic [3:0]  core_off;
  logic [3:0]  core_on;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_rst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .rst_level(rst_level), .core_off(core_off), .core_on(core_on)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Write w, then check pulses and stored value in the following cycle,
  // then check that the pulses are gone one cycle later.
  task automatic write_and_check(input logic [31:0] w, input string tag);
    logic [3:0] exp_off;
    logic [3:0] exp_on;
    exp_off = w[3:0] & ~shadow[3:0];
    exp_on  = ~w[3:0] & shadow[3:0];
    shadow  = w & ~RSVD;
    @(negedge clk);
    wr_en = 1'b1;
    wdata = w;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rd_en = 1'b1;
    check({tag, " R4 off"}, {28'd0, core_off}, {28'd0, exp_off});
    check({tag, " R5 on"}, {28'd0, core_on}, {28'd0, exp_on});
    check({tag, " R2 level"}, rst_level, shadow);
    check({tag, " R2 rdata"}, rdata, shadow);
    @(posedge clk);
    #1;
    check({tag, " R7 off width"}, {28'd0, core_off}, 32'd0);
    check({tag, " R7 on width"}, {28'd0, core_on}, 32'd0);
  endtask

  task automatic t_reset;
    @(posedge clk);
    #1;
    rd_en = 1'b1;
    #1;
    check("R1 level", rst_level, 32'h3D0F);
    check("R1 rdata", rdata, 32'h3D0F);
    check("R1 pulses", {24'd0, core_off, core_on}, 32'd0);
    shadow = 32'h3D0F;
  endtask

  task automatic t_release_all;
    write_and_check(32'h0000_3D00, "release all R5");
  endtask

  task automatic t_same_value;
    write_and_check(32'h0000_3D00, "rewrite R6");
  endtask

  task automatic t_partial_off;
    write_and_check(32'h0000_3D05, "partial off R4 R6");
  endtask

  task automatic t_swap;
    write_and_check(32'h0000_3D0A, "swap R7");
  endtask

  task automatic t_reserved;
    write_and_check(32'hFFFF_FFF0, "reserved R3");
    check("R3 rsvd bits", rst_level & RSVD, 32'd0);
  endtask

  task automatic t_idle_and_rd;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      #1;
      check("R8 idle", {24'd0, core_off, core_on}, 32'd0);
    end
    rd_en = 1'b0;
    #1;
    check("R9 rdata gated", rdata, 32'd0);
    check("R2 level held", rst_level, shadow);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    wr_en = 1'b1;
    wdata = 32'h0000_000F;
    @(posedge clk);
    #1;
    check("b2b R4 off", {28'd0, core_off}, 32'h0000_000F);
    @(negedge clk);
    wdata = 32'h0000_0000;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    check("b2b R5 on", {28'd0, core_on}, 32'h0000_000F);
    check("b2b R7 off gone", {28'd0, core_off}, 32'd0);
    shadow = 32'd0;
    @(posedge clk);
    #1;
    check("b2b R7 on gone", {28'd0, core_on}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_release_all();
    t_same_value();
    t_partial_off();
    t_swap();
    t_reserved();
    t_idle_and_rd();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule